// File: doc/BRIEF.md
# Nine-Track Tape Check Character Generator

This block forms the 9-bit cyclic check character that follows each record on a nine-track NRZI tape. Record bytes pass through it one per clock while a valid strobe is high. Before a byte enters the 9-bit accumulator, the block adds the byte's odd-parity bit above it. A start pulse clears the accumulator at the head of a record. An end pulse closes the record.

When the record closes, the block presents the finished check character. In write mode the caller appends that character to the record. In read mode the caller also supplies the 8-bit check byte that was read from tape. The block compares the data bits of its own result with that byte and raises either a match flag or a mismatch flag. The longitudinal check character and the tape channel itself are handled elsewhere.

Top module: `crcc_nrzi9`

## Requirements
- R1: After reset, `crc_o` is zero and `done_o`, `match_o` and `mismatch_o` are low.
- R2: A start pulse clears the accumulator. A byte presented in the same cycle as the start pulse is folded in as the first byte of the new record.
- R3: Each byte is widened to 9 bits. Bit 8 is its odd-parity bit, which is 1 when the byte holds an even number of ones. Bits 7..0 are the byte itself.
- R4: For each valid byte, the 9-bit value is XORed with the accumulator and the result is rotated right by one place within 9 bits, so that old bit 0 becomes bit 8. If bit 8 is then 1, the accumulator is XORed with octal 074.
- R5: A cycle without the valid strobe or the start pulse leaves the accumulator unchanged, so gaps inside a record do not alter the result.
- R6: After an end pulse, `crc_o` is set at the next clock edge to the accumulator XORed with octal 727. The accumulator value used here includes any byte presented in the same cycle as the end pulse. `done_o` is high for exactly that one following cycle.
- R7: In read mode (`wr_mode_i` = 0 during the end pulse), `match_o` goes high when `crc_o[7:0]` equals `rd_crc_i`, and `mismatch_o` goes high otherwise. Bit 8 takes no part in the comparison.
- R8: In write mode (`wr_mode_i` = 1 during the end pulse), `match_o` and `mismatch_o` are both low after the end pulse.
- R9: `crc_o`, `match_o` and `mismatch_o` keep their values until the next end pulse. A start pulse or new bytes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the accumulator for a new record |
| byte_valid_i | input | 1 | `byte_i` carries a record byte this cycle |
| byte_i | input | 8 | Record byte |
| end_i | input | 1 | Closes the record |
| wr_mode_i | input | 1 | 1 = write, 0 = read; sampled with `end_i` |
| rd_crc_i | input | 8 | Check byte read from tape; sampled with `end_i` |
| crc_o | output | 9 | Finished check character |
| done_o | output | 1 | One-cycle pulse after `end_i` |
| match_o | output | 1 | Read mode: the check bytes agree |
| mismatch_o | output | 1 | Read mode: the check bytes differ |

## Verification
Every one of the 256 one-byte records is sent, which covers both parity values and every carry of the conditional XOR. Longer records of zeros, ones, rising counts and pseudo-random bytes test how the accumulator chains from byte to byte. These records are sent with and without gaps in the strobe, which shows whether idle cycles leak into the result. Separate cases cover the empty record, a byte arriving with the end pulse, a byte arriving with the start pulse, and a restart in mid-record, each of which moves the record boundary by one byte. Read-mode records are checked once with the correct check byte, once with one data bit flipped, and once with only the parity bit wrong in the caller's copy, so the comparison is shown to use the data bits only.

// File: rtl/crcc_pkg.sv
package crcc_pkg;
  localparam int BYTE_W = 8;
  localparam int ACC_W  = BYTE_W + 1;

  typedef logic [ACC_W-1:0] acc_t;

  // odd parity: 1 when the byte holds an even number of ones
  function automatic logic odd_parity(input logic [BYTE_W-1:0] b);
    return ~(^b);
  endfunction

  function automatic acc_t widen(input logic [BYTE_W-1:0] b);
    return {odd_parity(b), b};
  endfunction

  // one byte step: xor, rotate right within ACC_W, conditional feedback
  function automatic acc_t fold(input acc_t acc, input logic [BYTE_W-1:0] b,
                                input acc_t poly);
    acc_t mix;
    acc_t rot;
    mix = widen(b) ^ acc;
    rot = {mix[0], mix[ACC_W-1:1]};
    if (rot[ACC_W-1]) rot = rot ^ poly;
    return rot;
  endfunction

  function automatic acc_t finish(input acc_t acc, input acc_t fin_xor);
    return acc ^ fin_xor;
  endfunction
endpackage

// File: rtl/crcc_accum.sv
module crcc_accum
  import crcc_pkg::*;
#(
  parameter acc_t POLY = 9'o074
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              valid,
  input  logic [BYTE_W-1:0] data,
  output acc_t              acc_q,
  output acc_t              acc_next
);
  acc_t base;

  always_comb begin
    base     = start ? '0 : acc_q;
    acc_next = valid ? fold(base, data, POLY) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_next;
  end
endmodule

// File: rtl/crcc_result.sv
module crcc_result
  import crcc_pkg::*;
#(
  parameter acc_t FIN_XOR = 9'o727
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close,
  input  logic              wr_mode,
  input  logic [BYTE_W-1:0] tape_chk,
  input  acc_t              acc_in,
  output acc_t              chk_q,
  output logic              done_q,
  output logic              match_q,
  output logic              miss_q
);
  acc_t chk_n;
  logic agree;

  always_comb begin
    chk_n = finish(acc_in, FIN_XOR);
    agree = (chk_n[BYTE_W-1:0] == tape_chk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q   <= '0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      done_q <= close;
      if (close) begin
        chk_q   <= chk_n;
        match_q <= !wr_mode && agree;
        miss_q  <= !wr_mode && !agree;
      end
    end
  end
endmodule

// File: rtl/crcc_nrzi9.sv
module crcc_nrzi9
  import crcc_pkg::*;
#(
  parameter acc_t POLY    = 9'o074,
  parameter acc_t FIN_XOR = 9'o727
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              end_i,
  input  logic              wr_mode_i,
  input  logic [BYTE_W-1:0] rd_crc_i,
  output logic [ACC_W-1:0]  crc_o,
  output logic              done_o,
  output logic              match_o,
  output logic              mismatch_o
);
  acc_t acc_state;   // brought out for the checker
  acc_t acc_fed;     // accumulator including this cycle's byte

  crcc_accum #(.POLY(POLY)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .valid    (byte_valid_i),
    .data     (byte_i),
    .acc_q    (acc_state),
    .acc_next (acc_fed)
  );

  crcc_result #(.FIN_XOR(FIN_XOR)) u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .close    (end_i),
    .wr_mode  (wr_mode_i),
    .tape_chk (rd_crc_i),
    .acc_in   (acc_fed),
    .chk_q    (crc_o),
    .done_q   (done_o),
    .match_q  (match_o),
    .miss_q   (mismatch_o)
  );
endmodule

// File: rtl/crcc_nrzi9_chk.sv
module crcc_nrzi9_chk #(
  parameter int ACC_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             byte_valid_i,
  input logic             end_i,
  input logic             wr_mode_i,
  input logic [ACC_W-1:0] acc_state,
  input logic [ACC_W-1:0] crc_o,
  input logic             done_o,
  input logic             match_o,
  input logic             mismatch_o
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !byte_valid_i |=> acc_state == '0);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !byte_valid_i |=> $stable(acc_state));

  a_r6_done_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> done_o);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !end_i |=> !done_o);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_o && mismatch_o));

  a_r7_read_decides: assert property (@(posedge clk) disable iff (!rst_n)
    end_i && !wr_mode_i |=> $countones({match_o, mismatch_o}) == 1);

  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    end_i && wr_mode_i |=> !match_o && !mismatch_o);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !end_i |=> $stable(crc_o) && $stable(match_o) && $stable(mismatch_o));
endmodule

bind crcc_nrzi9 crcc_nrzi9_chk #(.ACC_W(crcc_pkg::ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .byte_valid_i (byte_valid_i),
  .end_i        (end_i),
  .wr_mode_i    (wr_mode_i),
  .acc_state    (acc_state),
  .crc_o        (crc_o),
  .done_o       (done_o),
  .match_o      (match_o),
  .mismatch_o   (mismatch_o)
);

// File: tb/crcc_nrzi9_test.sv
module crcc_nrzi9_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, byte_valid_i = 1'b0, end_i = 1'b0, wr_mode_i = 1'b1;
  logic [7:0] byte_i = '0, rd_crc_i = '0;
  logic [8:0] crc_o;
  logic       done_o, match_o, mismatch_o;

  int tests = 0, fails = 0;
  logic [7:0] rec [0:63];

  always #2 clk = ~clk;   // 250 MHz

  crcc_nrzi9 uut (.*);

  // bench model, written arithmetically
  function automatic int ref_step(input int acc, input int b);
    int ones = 0;
    int v, t, r;
    for (int k = 0; k < 8; k++) ones += (b >> k) & 1;
    v = b + (((ones % 2) == 0) ? 256 : 0);
    t = v ^ acc;
    r = (t >> 1) + ((t & 1) * 256);
    if (r >= 256) r = r ^ 60;      // octal 074
    return r;
  endfunction

  function automatic int ref_crc(input int n);
    int acc = 0;
    for (int i = 0; i < n; i++) acc = ref_step(acc, int'(rec[i]));
    return acc ^ 471;              // octal 727
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives at negedge; byte k in same cycle as end when tail_with_end
  task automatic send(input int n, input bit gaps, input bit tail_with_end,
                      input bit wr, input logic [7:0] tape);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_valid_i = 1'b1; byte_i = rec[i];
      if (tail_with_end && i == n - 1) begin
        end_i = 1'b1; wr_mode_i = wr; rd_crc_i = tape;
      end
      @(negedge clk);
      byte_valid_i = 1'b0; byte_i = 8'hxx;
      if (gaps) begin
        byte_i = 8'hA5;
        repeat (2) @(negedge clk);
      end
    end
    if (!(tail_with_end && n > 0)) begin
      end_i = 1'b1; wr_mode_i = wr; rd_crc_i = tape;
      @(negedge clk);
    end
    end_i = 1'b0; rd_crc_i = ~tape;
  endtask

  int e;
  initial begin
    repeat (3) @(negedge clk);
    check("R1 crc", int'(crc_o), 0);
    check("R1 flags", int'({done_o, match_o, mismatch_o}), 0);
    rst_n = 1'b1;

    // R3 R4 R6: every single-byte record in write mode
    for (int b = 0; b < 256; b++) begin
      rec[0] = 8'(b);
      send(1, 0, 0, 1, 8'h00);
      check("R4 single byte", int'(crc_o), ref_crc(1));
      check("R8 write flags", int'({match_o, mismatch_o}), 0);
    end

    // R6: empty record and done pulse width
    send(0, 0, 0, 1, 8'h00);
    check("R6 empty", int'(crc_o), 471);
    check("R6 done high", int'(done_o), 1);
    @(negedge clk);
    check("R6 done one cycle", int'(done_o), 0);

    // multi-byte patterns, with and without gaps (R5)
    for (int p = 0; p < 4; p++) begin
      int lfsr = 8'h5B;
      for (int i = 0; i < 40; i++) begin
        case (p)
          0: rec[i] = 8'h00;
          1: rec[i] = 8'hFF;
          2: rec[i] = 8'(i * 7);
          default: begin
            lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 255;
            rec[i] = 8'(lfsr);
          end
        endcase
      end
      send(40, 0, 0, 1, 8'h00);
      check("R4 pattern", int'(crc_o), ref_crc(40));
      send(40, 1, 0, 1, 8'h00);
      check("R5 gaps", int'(crc_o), ref_crc(40));
    end

    // R6: last byte with the end pulse
    send(17, 0, 1, 1, 8'h00);
    check("R6 byte with end", int'(crc_o), ref_crc(17));

    // R7: read mode, correct, one data bit wrong, parity-only difference
    e = ref_crc(25);
    send(25, 0, 0, 0, 8'(e));
    check("R7 match", int'({match_o, mismatch_o}), 2);
    check("R7 crc in read", int'(crc_o), e);
    send(25, 0, 0, 0, 8'(e) ^ 8'h10);
    check("R7 mismatch", int'({match_o, mismatch_o}), 1);
    send(25, 1, 1, 0, 8'(e));   // same low bits, bit 8 not present on tape input
    check("R7 parity ignored", int'({match_o, mismatch_o}), 2);

    // R9: outputs hold across start and bytes
    @(negedge clk); start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h3C;
    @(negedge clk); start_i = 1'b0; byte_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 crc held", int'(crc_o), e);
    check("R9 flags held", int'({match_o, mismatch_o}), 2);

    // R2: byte with start, then restart mid-record
    rec[0] = 8'h3C;
    @(negedge clk); end_i = 1'b1; wr_mode_i = 1'b1;
    @(negedge clk); end_i = 1'b0;
    check("R2 byte with start", int'(crc_o), ref_crc(1));
    @(negedge clk); byte_valid_i = 1'b1; byte_i = 8'h99;
    @(negedge clk); byte_valid_i = 1'b0;
    rec[0] = 8'h12; rec[1] = 8'hE7;
    send(2, 0, 0, 1, 8'h00);
    check("R2 restart", int'(crc_o), ref_crc(2));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule